// File: doc/BRIEF.md
# Shared-Slot Virtual-Channel Elastic Buffer

This block is a link-level pipeline stage for a channel that multiplexes several virtual channels over a single flit bus. On each side there is one data bus and one valid/ready pair for each virtual channel. A flit of channel `i` moves when `valid[i]` and `ready[i]` are both high at a rising clock edge. Every output of the block comes from a flop: the data bus, each valid and each ready. The block can therefore be placed in the middle of a long link to cut timing paths without losing per-channel flow control.

Storage is one holding register per virtual channel plus one spare slot that all channels share. An incoming flit goes into its channel's register when that register will be free. Otherwise it goes into the spare slot. When a channel's register drains while the spare slot holds a flit of the same channel, that flit moves into the register on the same edge, so the channel's stream has no gap. Each cycle a round-robin choice picks one channel among those that have a stored flit and whose downstream ready was high, and offers that flit on the next cycle.

Top module: `vc_pool_buffer`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with no input, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: The upstream side drives at most one `in_valid` bit at a time. A flit of channel `i` is accepted exactly when `in_valid[i]` and `in_ready[i]` are both high at a rising edge.
- R3: `in_ready[i]` is low only while channel `i` holds a flit in its own register and the shared slot is occupied. Total storage never exceeds one flit per channel plus one.
- R4: Every accepted flit leaves exactly once, on its own channel and in arrival order. A flit that is offered but not taken stays stored and is offered again with the same data.
- R5: At most one `out_valid` bit is high in any cycle. `out_valid[i]` is high only if `out_ready[i]` was high in the previous cycle and channel `i` holds a flit.
- R6: With `out_ready[i]` held high and flits of channel `i` arriving on every cycle, channel `i` delivers one flit per cycle with no idle cycle between them.
- R7: When several channels hold flits and all their downstream readies are high, the grants rotate. Two consecutive grants never go to the same channel while another eligible channel is waiting.
- R8: A channel whose downstream ready stays low does not stop the other channels from accepting and delivering flits, even while its flit occupies the shared slot.
- R9: When a channel's register drains while the shared slot holds that channel's next flit, the flit is offered on the next cycle, with no idle cycle on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | FLIT_W | Upstream flit bus, shared by all channels |
| in_valid | input | NUM_VC | Upstream valid, one bit per channel |
| in_ready | output | NUM_VC | Registered upstream ready, one bit per channel |
| out_data | output | FLIT_W | Registered downstream flit bus |
| out_valid | output | NUM_VC | Registered downstream valid, one bit per channel |
| out_ready | input | NUM_VC | Downstream ready, one bit per channel |

## Verification
The bound checker watches the following on every cycle:
- the single-hot valid buses;
- that an offer is made only on a stored flit whose ready was seen high;
- that a refused offer keeps its data;
- that ready drops only when both the channel's register and the shared slot are occupied.

Ordering, loss and duplication within each channel need the bench's per-channel queues under random stalls. The same holds for cycle-level behaviour: back-to-back delivery on one channel, the gap-free refill from the shared slot, the alternation of grants, and progress of one channel while another is held.

// File: rtl/vc_pool_pkg.sv
package vc_pool_pkg;

    localparam int VC_ID_W = 5;
    localparam int MAX_VC  = 1 << VC_ID_W;

    typedef logic [VC_ID_W-1:0] vc_id_t;

    // Tag of the single spare slot: occupancy and owning channel.
    typedef struct packed {
        logic   busy;
        vc_id_t owner;
    } spare_tag_t;

    // Index reached by stepping off places from base on a ring of n entries.
    function automatic int ring_idx(input int base, input int off, input int n);
        int s;
        s = base + off;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/vc_pool_store.sv
module vc_pool_store
    import vc_pool_pkg::*;
#(
    parameter int N = 2,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        wr_data,
    input  logic [N-1:0]        wr_take,
    input  logic [N-1:0]        rd_take,
    output logic [N-1:0]        main_full_q,
    output logic                sh_full_q,
    output logic [N-1:0]        main_full_nx,
    output logic [N-1:0][W-1:0] main_data_nx,
    output logic                sh_full_nx
);

    logic [N-1:0][W-1:0] main_data_q;
    logic [W-1:0]        sh_data_q, sh_data_nx;
    spare_tag_t          tag_q, tag_nx;

    always_comb begin
        main_full_nx = main_full_q & ~rd_take;
        main_data_nx = main_data_q;
        tag_nx       = tag_q;
        sh_data_nx   = sh_data_q;
        // Refill a drained register from the spare slot it owns.
        for (int i = 0; i < N; i++) begin
            if (!main_full_nx[i] && tag_q.busy && tag_q.owner == vc_id_t'(i)) begin
                main_full_nx[i] = 1'b1;
                main_data_nx[i] = sh_data_q;
                tag_nx.busy     = 1'b0;
            end
        end
        // Place the arriving flit behind anything already held for its channel.
        for (int i = 0; i < N; i++) begin
            if (wr_take[i]) begin
                if (main_full_nx[i]) begin
                    tag_nx.busy  = 1'b1;
                    tag_nx.owner = vc_id_t'(i);
                    sh_data_nx   = wr_data;
                end else begin
                    main_full_nx[i] = 1'b1;
                    main_data_nx[i] = wr_data;
                end
            end
        end
    end

    assign sh_full_nx = tag_nx.busy;
    assign sh_full_q  = tag_q.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_full_q <= '0;
            tag_q       <= '0;
        end else begin
            main_full_q <= main_full_nx;
            tag_q       <= tag_nx;
        end
        main_data_q <= main_data_nx;
        sh_data_q   <= sh_data_nx;
    end

endmodule

// File: rtl/vc_pool_rr.sv
module vc_pool_rr
    import vc_pool_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        grant = '0;
        ptr_d = ptr_q;
        for (int k = 0; k < N; k++) begin
            if (grant == '0 && req[ring_idx(int'(ptr_q), k, N)]) begin
                grant[ring_idx(int'(ptr_q), k, N)] = 1'b1;
                ptr_d = PW'(ring_idx(int'(ptr_q), k + 1, N));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

endmodule

// File: rtl/vc_pool_buffer.sv
module vc_pool_buffer
    import vc_pool_pkg::*;
#(
    parameter int NUM_VC = 2,
    parameter int FLIT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] in_data,
    input  logic [NUM_VC-1:0] in_valid,
    output logic [NUM_VC-1:0] in_ready,
    output logic [FLIT_W-1:0] out_data,
    output logic [NUM_VC-1:0] out_valid,
    input  logic [NUM_VC-1:0] out_ready
);

    logic [NUM_VC-1:0]             in_take, out_take;
    logic [NUM_VC-1:0]             main_full_q, main_full_nx, grant, ready_nx;
    logic [NUM_VC-1:0][FLIT_W-1:0] main_data_nx;
    logic                          sh_full_q, sh_full_nx;
    logic [FLIT_W-1:0]             sel_data;

    assign in_take  = in_valid & in_ready;
    assign out_take = out_valid & out_ready;

    vc_pool_store #(.N(NUM_VC), .W(FLIT_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_data      (in_data),
        .wr_take      (in_take),
        .rd_take      (out_take),
        .main_full_q  (main_full_q),
        .sh_full_q    (sh_full_q),
        .main_full_nx (main_full_nx),
        .main_data_nx (main_data_nx),
        .sh_full_nx   (sh_full_nx)
    );

    vc_pool_rr #(.N(NUM_VC)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (main_full_nx & out_ready),
        .grant (grant)
    );

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NUM_VC; i++)
            if (grant[i]) sel_data = sel_data | main_data_nx[i];
    end

    for (genvar g = 0; g < NUM_VC; g++) begin : g_ready
        assign ready_nx[g] = !main_full_nx[g] || !sh_full_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= '0;
            in_ready  <= '1;
            out_data  <= '0;
        end else begin
            out_valid <= grant;
            in_ready  <= ready_nx;
            out_data  <= sel_data;
        end
    end

endmodule

// File: rtl/vc_pool_buffer_chk.sv
module vc_pool_buffer_chk #(
    parameter int N = 2,
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] in_valid,
    input logic [N-1:0] in_ready,
    input logic [N-1:0] out_valid,
    input logic [N-1:0] out_ready,
    input logic [W-1:0] out_data,
    input logic [N-1:0] main_full,
    input logic         sh_full
);

    p_in_single_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_valid));

    p_out_single_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> out_valid == '0);

    for (genvar g = 0; g < N; g++) begin : g_vc
        p_offer_stored_r5: assert property (@(posedge clk) disable iff (rst)
            out_valid[g] |-> main_full[g]);

        p_offer_after_ready_r5: assert property (@(posedge clk) disable iff (rst)
            out_valid[g] |-> $past(out_ready[g]));

        p_refused_kept_r4: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && !out_ready[g]) |=> main_full[g]);

        p_refused_same_data_r4: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && !out_ready[g]) |=> (out_valid[g] -> $stable(out_data)));

        p_ready_low_full_r3: assert property (@(posedge clk) disable iff (rst)
            !in_ready[g] |-> (main_full[g] && sh_full));
    end

endmodule

bind vc_pool_buffer vc_pool_buffer_chk #(.N(NUM_VC), .W(FLIT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .main_full (main_full_q),
    .sh_full   (sh_full_q)
);

// File: tb/vc_pool_buffer_tb_top.sv
module vc_pool_buffer_tb_top;

    localparam int NV = 2;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  in_data = '0;
    logic [NV-1:0] in_valid = '0, in_ready, out_valid, out_ready = '0;
    logic [W-1:0]  out_data;

    always #2 clk = ~clk;

    vc_pool_buffer #(.NUM_VC(NV), .FLIT_W(W)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    int checks = 0, fails = 0, cyc = 0, idle_pct = 0, sent = 0, delivered = 0, seq = 0;
    int omode [NV];
    logic [W-1:0] src_q [NV][$];
    logic [W-1:0] mdl_q [NV][$];
    int xvc [$];
    int xcyc [$];
    logic [NV-1:0] p_in_v = '0, p_in_r = '0, p_out_v = '0, p_out_r = '0;
    logic [W-1:0]  p_in_d = '0, p_out_d = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic load(input int v, input int n);
        for (int k = 0; k < n; k++) begin
            src_q[v].push_back(W'((v << 12) | (seq & 12'hfff)));
            seq++;
            sent++;
        end
    endtask

    task automatic clear_log();
        xvc.delete();
        xcyc.delete();
    endtask

    // Behavioural reference: per-channel queues of stored flits, updated on every clock.
    always @(negedge clk) begin
        int total;
        int pick;
        int v0;
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R4", "watchdog expired", cyc, 150000);
            finish_run();
        end
        // Transfers that happened at the last rising edge.
        for (int v = 0; v < NV; v++) begin
            if (p_out_v[v] && p_out_r[v]) begin
                chk(mdl_q[v].size() > 0 && mdl_q[v][0] == p_out_d, "R4",
                    "delivered flit", p_out_d, mdl_q[v].size() > 0 ? mdl_q[v][0] : 0);
                if (mdl_q[v].size() > 0) void'(mdl_q[v].pop_front());
                xvc.push_back(v);
                xcyc.push_back(cyc);
                delivered++;
            end
        end
        for (int v = 0; v < NV; v++) begin
            if (p_in_v[v] && p_in_r[v]) begin
                mdl_q[v].push_back(p_in_d);
                void'(src_q[v].pop_front());
            end
        end
        // Current registered outputs against the model.
        if (!rst) begin
            total = 0;
            for (int v = 0; v < NV; v++) total += mdl_q[v].size();
            chk(total <= NV + 1, "R3", "stored flits", total, NV + 1);
            chk($countones(out_valid) <= 1, "R5", "out_valid bits", $countones(out_valid), 1);
            for (int v = 0; v < NV; v++) begin
                if (out_valid[v]) begin
                    chk(mdl_q[v].size() > 0 && out_data == mdl_q[v][0], "R4", "offered flit",
                        out_data, mdl_q[v].size() > 0 ? mdl_q[v][0] : 0);
                    chk(p_out_r[v] == 1'b1, "R5", "offer without prior ready", 0, 1);
                end
                if (!in_ready[v])
                    chk(mdl_q[v].size() >= 1 && total >= 2, "R3", "ready low with room",
                        total, 2);
            end
        end
        // Drive the next cycle.
        for (int v = 0; v < NV; v++)
            out_ready[v] = (omode[v] == 2) ? 1'($urandom_range(0, 1)) : 1'(omode[v] == 1);
        in_valid = '0;
        pick = -1;
        if (!rst && $urandom_range(0, 99) >= idle_pct) begin
            v0 = $urandom_range(0, NV - 1);
            for (int k = 0; k < NV; k++) begin
                int v;
                v = (v0 + k) % NV;
                if (pick < 0 && src_q[v].size() > 0 &&
                    (in_ready[v] || $urandom_range(0, 3) == 0))
                    pick = v;
            end
        end
        if (pick >= 0) begin
            in_valid[pick] = 1'b1;
            in_data = src_q[pick][0];
        end
        p_in_v = in_valid;  p_in_r = in_ready;  p_in_d = in_data;
        p_out_v = out_valid; p_out_r = out_ready; p_out_d = out_data;
    end

    initial begin
        int guard;
        int n1;
        bit hit0;
        for (int v = 0; v < NV; v++) omode[v] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 3);

        // R6 single-channel streaming
        for (int v = 0; v < NV; v++) omode[v] = 1;
        clear_log();
        load(0, 8);
        guard = 0;
        while (xvc.size() < 8 && guard < 60) begin @(negedge clk); guard++; end
        chk(xvc.size() == 8, "R6", "streamed flits", xvc.size(), 8);
        if (xcyc.size() >= 8)
            chk(xcyc[7] - xcyc[0] == 7, "R6", "cycles spanned by 8 flits", xcyc[7] - xcyc[0], 7);

        // R3 / R9 fill register and shared slot, then release
        omode[0] = 0;
        load(0, 2);
        repeat (8) @(negedge clk);
        chk(mdl_q[0].size() == 2, "R3", "stored on held channel", mdl_q[0].size(), 2);
        chk(in_ready[0] == 1'b0, "R3", "ready of full channel", in_ready[0], 0);
        chk(in_ready[1] == 1'b1, "R8", "ready of other channel", in_ready[1], 1);
        clear_log();
        omode[0] = 1;
        guard = 0;
        while (xvc.size() < 2 && guard < 20) begin @(negedge clk); guard++; end
        chk(xvc.size() == 2, "R9", "flits after release", xvc.size(), 2);
        if (xcyc.size() >= 2)
            chk(xcyc[1] - xcyc[0] == 1, "R9", "gap after refill", xcyc[1] - xcyc[0], 1);

        // R8 held channel occupies the shared slot, other channel keeps moving
        omode[0] = 0;
        load(0, 2);
        repeat (8) @(negedge clk);
        clear_log();
        load(1, 5);
        repeat (40) @(negedge clk);
        n1 = 0; hit0 = 1'b0;
        foreach (xvc[k]) begin
            if (xvc[k] == 1) n1++;
            else hit0 = 1'b1;
        end
        chk(n1 == 5, "R8", "flits through free channel", n1, 5);
        chk(!hit0, "R8", "held channel delivered", hit0, 0);
        chk(mdl_q[0].size() == 2, "R8", "held channel stored", mdl_q[0].size(), 2);

        // R7 rotation between two eligible channels
        omode[1] = 0;
        load(1, 1);
        repeat (8) @(negedge clk);
        chk(mdl_q[1].size() == 1, "R7", "channel 1 stored", mdl_q[1].size(), 1);
        clear_log();
        for (int v = 0; v < NV; v++) omode[v] = 1;
        guard = 0;
        while (xvc.size() < 3 && guard < 20) begin @(negedge clk); guard++; end
        chk(xvc.size() == 3, "R7", "flits delivered", xvc.size(), 3);
        if (xvc.size() >= 3) begin
            chk(xvc[0] != xvc[1], "R7", "second grant channel", xvc[1], 1 - xvc[0]);
            chk(xvc[2] == 0, "R7", "third grant channel", xvc[2], 0);
        end

        // R4 random stalls on every channel, then drain
        for (int v = 0; v < NV; v++) omode[v] = 2;
        idle_pct = 30;
        for (int v = 0; v < NV; v++) load(v, 200);
        guard = 0;
        while ((src_q[0].size() + src_q[1].size()) > 0 && guard < 20000) begin
            @(negedge clk); guard++;
        end
        for (int v = 0; v < NV; v++) omode[v] = 1;
        repeat (20) @(negedge clk);
        chk(src_q[0].size() + src_q[1].size() == 0, "R2", "unsent flits",
            src_q[0].size() + src_q[1].size(), 0);
        chk(mdl_q[0].size() + mdl_q[1].size() == 0, "R4", "flits left stored",
            mdl_q[0].size() + mdl_q[1].size(), 0);
        chk(delivered == sent, "R4", "delivered count", delivered, sent);
        finish_run();
    end

endmodule